// File: doc/BRIEF.md
# RTC Interrupt Event and Enable Controller

This block gathers the five interrupt sources of a real-time clock: calibration start, calibration finish, comparator match, one-second tick and alarm. It holds three views of them behind one small register port:
- a registered copy of the raw source levels;
- a sticky event register that latches each rising edge;
- an enable mask.

A single level interrupt line is raised while any enabled event is pending.

Software acknowledges events by writing ones to the event register. The top bit of that register is a write-only command bit. Writing a one there sends a one-cycle load pulse to the calendar block, which copies the configured time and date into its running counters.

The raw one-second level lets software spot a seconds rollover that happens during a multi-word time read. To do so, it samples that level before and after the read.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no further activity, the enable, event and raw-status registers read zero, `irq_o` is low and `upd_pulse_o` is low.
- R2: A rising edge on `src_i[k]` sets event bit k one clock later, whatever the enable mask holds. A source that stays high does not set the bit again once it has been cleared.
- R3: A write to the event register (address 0x4) clears every event bit written as 1. Event bits written as 0 keep their value.
- R4: If a rising edge of a source and a write-one-clear of the same event bit fall in the same cycle, the event bit stays set.
- R5: `irq_o` is high exactly when some event bit and the matching enable bit (address 0x0, bits 4:0) are both set.
- R6: A write with bit 31 set to the event register drives `upd_pulse_o` high for the one cycle after the write. That bit clears no event and reads back as 0.
- R7: The raw-status register (address 0x8) returns the source levels sampled at the previous clock edge.
- R8: All three registers share one bit layout: bit 0 calibration start, bit 1 calibration finish, bit 2 compare, bit 3 one-second, bit 4 alarm. Bits 5 to 30 read as zero and ignore writes.
- R9: Any read address other than 0x0, 0x4 and 0x8 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 5 | Interrupt source levels, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read byte address |
| rd_data_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| upd_pulse_o | output | 1 | One-cycle calendar load pulse |

## Verification
The bench builds the block with its defaults: five sources, a 32-bit data word and a 4-bit address. With these values the command bit at position 31, the unused field in bits 5 to 30 and an unmapped fourth address slot can all be reached from the ports.

A vector table walks edge capture, partial clears and mask changes. Directed steps then cover:
- an edge that lands in the same cycle as its own clear;
- the command bit written alone;
- a reset taken while events are pending.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  localparam int DEF_NUM_SRC    = 5;
  localparam int DEF_DATA_W     = 32;
  localparam int DEF_ADDR_W     = 4;

  localparam int SRC_CAL_START  = 0;
  localparam int SRC_CAL_DONE   = 1;
  localparam int SRC_COMPARE    = 2;
  localparam int SRC_ONE_SEC    = 3;
  localparam int SRC_ALARM      = 4;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_EVENT = 2'd1,
    SEL_RAW   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // next sticky state: a new edge always wins over a clear
  function automatic logic [DEF_DATA_W-1:0] sticky_next(
    input logic [DEF_DATA_W-1:0] cur,
    input logic [DEF_DATA_W-1:0] clr,
    input logic [DEF_DATA_W-1:0] rise
  );
    return (cur & ~clr) | rise;
  endfunction

  // any pending event that is also unmasked
  function automatic logic irq_any(
    input logic [DEF_DATA_W-1:0] evt,
    input logic [DEF_DATA_W-1:0] ena
  );
    return |(evt & ena);
  endfunction

endpackage

// File: rtl/rtc_irq_edge.sv
module rtc_irq_edge #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] lvl_o,
  output logic [NUM_SRC-1:0] rise_o
);

  logic [NUM_SRC-1:0] lvl_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[k] <= 1'b0;
      else        lvl_q[k] <= src_i[k];
    end
    assign rise_o[k] = src_i[k] & ~lvl_q[k];
  end

  assign lvl_o = lvl_q;

  AST_RAW_TRACKS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_o == $past(src_i)));  // R7

endmodule

// File: rtl/rtc_irq_evt.sv
module rtc_irq_evt
  import rtc_irq_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] evt_o
);

  localparam int PADW = DEF_DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0]    evt_q;
  logic [DEF_DATA_W-1:0] nxt_full;
  logic [NUM_SRC-1:0]    unused_nxt_hi;

  assign nxt_full = sticky_next({{PADW{1'b0}}, evt_q},
                                {{PADW{1'b0}}, clr_i},
                                {{PADW{1'b0}}, rise_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= nxt_full[NUM_SRC-1:0];
  end

  assign unused_nxt_hi = nxt_full[NUM_SRC-1:0] ^ evt_q;
  assign evt_o = evt_q;

  AST_EDGE_SETS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != '0) |=> ((evt_o & $past(rise_i)) == $past(rise_i)));  // R2

  AST_EVT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_o & ~$past(evt_o) & ~$past(rise_i)) == '0));  // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~rise_i) != '0) |=> ((evt_o & $past(clr_i & ~rise_i)) == '0));  // R3

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & rise_i) != '0) |=> ((evt_o & $past(clr_i & rise_i)) == $past(clr_i & rise_i)));  // R4

endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
#(
  parameter int NUM_SRC  = 5,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int OFS_MASK = 0,
  parameter int OFS_EVT  = 4,
  parameter int OFS_RAW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  output logic [NUM_SRC-1:0] ena_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               upd_pulse_o
);

  localparam int                STROBE_BIT = DATA_W - 1;
  localparam int                PADW       = DATA_W - NUM_SRC;
  localparam logic [ADDR_W-1:0] A_MASK     = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_EVT      = ADDR_W'(OFS_EVT);
  localparam logic [ADDR_W-1:0] A_RAW      = ADDR_W'(OFS_RAW);

  logic [NUM_SRC-1:0] ena_q;
  logic               upd_q;
  logic               hit_mask;
  logic               hit_evt;
  logic               strobe_req;
  reg_sel_e           rsel;
  logic [DATA_W-NUM_SRC-2:0] unused_wdata_mid;

  assign hit_mask   = wr_en_i && (wr_addr_i == A_MASK);
  assign hit_evt    = wr_en_i && (wr_addr_i == A_EVT);
  assign strobe_req = hit_evt && wr_data_i[STROBE_BIT];
  assign clr_o      = hit_evt ? wr_data_i[NUM_SRC-1:0] : '0;
  assign unused_wdata_mid = wr_data_i[STROBE_BIT-1:NUM_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      upd_q <= 1'b0;
    end else begin
      if (hit_mask) ena_q <= wr_data_i[NUM_SRC-1:0];
      upd_q <= strobe_req;
    end
  end

  always_comb begin
    if      (rd_addr_i == A_MASK) rsel = SEL_MASK;
    else if (rd_addr_i == A_EVT)  rsel = SEL_EVENT;
    else if (rd_addr_i == A_RAW)  rsel = SEL_RAW;
    else                          rsel = SEL_NONE;
  end

  always_comb begin
    case (rsel)
      SEL_MASK:  rd_data_o = {{PADW{1'b0}}, ena_q};
      SEL_EVENT: rd_data_o = {{PADW{1'b0}}, evt_i};
      SEL_RAW:   rd_data_o = {{PADW{1'b0}}, lvl_i};
      default:   rd_data_o = '0;
    endcase
  end

  assign ena_o       = ena_q;
  assign upd_pulse_o = upd_q;

  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse_o |-> $past(wr_en_i && (wr_addr_i == A_EVT) && wr_data_i[STROBE_BIT]));  // R6

  AST_WRITE_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_addr_i == A_EVT) && wr_data_i[STROBE_BIT]) |=> upd_pulse_o);  // R6

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && (wr_addr_i == A_MASK)) |=> $stable(ena_o));  // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_addr_i != A_MASK) && (rd_addr_i != A_EVT) && (rd_addr_i != A_RAW)) |-> (rd_data_o == '0));  // R9

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int DATA_W  = DEF_DATA_W,
  parameter int ADDR_W  = DEF_ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o,
  output logic               upd_pulse_o
);

  localparam int PADW = DEF_DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] lvl_w;
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] clr_w;
  logic [NUM_SRC-1:0] evt_w;
  logic [NUM_SRC-1:0] ena_w;

  rtc_irq_edge #(.NUM_SRC(NUM_SRC)) i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .lvl_o  (lvl_w),
    .rise_o (rise_w)
  );

  rtc_irq_evt #(.NUM_SRC(NUM_SRC)) i_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (rise_w),
    .clr_i  (clr_w),
    .evt_o  (evt_w)
  );

  rtc_irq_regs #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .evt_i       (evt_w),
    .lvl_i       (lvl_w),
    .ena_o       (ena_w),
    .clr_o       (clr_w),
    .rd_data_o   (rd_data_o),
    .upd_pulse_o (upd_pulse_o)
  );

  assign irq_o = irq_any({{PADW{1'b0}}, evt_w}, {{PADW{1'b0}}, ena_w});

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ena_w != '0));  // R5

  AST_IRQ_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (evt_w != '0));  // R5

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && !upd_pulse_o));  // R1

endmodule

// File: tb/test_rtc_irq_ctrl.sv
module test_rtc_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_MASK = 4'h0;
  localparam logic [3:0] A_EVT  = 4'h4;
  localparam logic [3:0] A_RAW  = 4'h8;
  localparam logic [3:0] A_NONE = 4'hC;

  typedef struct packed {
    logic [4:0]  src;
    logic        wr;
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic [3:0]  raddr;
    logic [31:0] rexp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{5'h01, 1'b0, A_MASK, 32'h0,        A_EVT,  32'h01, 1'b0, 4'd2}, // R2 edge sets while masked
    '{5'h01, 1'b1, A_MASK, 32'hFFFFFFFF, A_MASK, 32'h1F, 1'b1, 4'd8}, // R8 high mask bits dropped
    '{5'h01, 1'b1, A_EVT,  32'h00000001, A_EVT,  32'h00, 1'b0, 4'd3}, // R3 clear
    '{5'h01, 1'b0, A_MASK, 32'h0,        A_EVT,  32'h00, 1'b0, 4'd2}, // R2 held level no re-set
    '{5'h14, 1'b0, A_MASK, 32'h0,        A_RAW,  32'h14, 1'b1, 4'd7}, // R7 raw levels
    '{5'h14, 1'b0, A_MASK, 32'h0,        A_EVT,  32'h14, 1'b1, 4'd2},
    '{5'h14, 1'b1, A_EVT,  32'h00000004, A_EVT,  32'h10, 1'b1, 4'd3}, // R3 partial clear
    '{5'h14, 1'b1, A_MASK, 32'h0000000F, A_EVT,  32'h10, 1'b0, 4'd5}, // R5 alarm masked
    '{5'h1E, 1'b0, A_MASK, 32'h0,        A_EVT,  32'h1A, 1'b1, 4'd5}, // R5 new enabled events
    '{5'h1E, 1'b1, A_MASK, 32'h0,        A_MASK, 32'h00, 1'b0, 4'd5},
    '{5'h1E, 1'b1, A_EVT,  32'h7FFFFFE0, A_EVT,  32'h1A, 1'b0, 4'd8}, // R8 gap bits ignored
    '{5'h1E, 1'b1, A_EVT,  32'hFFFFFFFF, A_EVT,  32'h00, 1'b0, 4'd3},
    '{5'h00, 1'b0, A_MASK, 32'h0,        A_NONE, 32'h00, 1'b0, 4'd9}, // R9 unmapped
    '{5'h00, 1'b0, A_MASK, 32'h0,        A_RAW,  32'h00, 1'b0, 4'd7}
  };

  logic        clk;
  logic        rst_n;
  logic [4:0]  src;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq;
  logic        upd;
  int          n_chk;
  int          n_bad;
  bit          done;

  rtc_irq_ctrl i_rtc_irq_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .irq_o       (irq),
    .upd_pulse_o (upd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [4:0] s, input logic w, input logic [3:0] wa,
                      input logic [31:0] wd, input logic [3:0] ra);
    src = s; wr_en = w; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; src = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = A_MASK;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_addr = A_MASK; #1 check("R1 mask", rd_data, 32'h0);
    rd_addr = A_EVT;  #1 check("R1 event", rd_data, 32'h0);
    rd_addr = A_RAW;  #1 check("R1 raw", rd_data, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 pulse", {31'b0, upd}, 32'h0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].src, VECS[i].wr, VECS[i].waddr, VECS[i].wdata, VECS[i].raddr);
      check($sformatf("R%0d vec%0d rd", VECS[i].req, i), rd_data, VECS[i].rexp);
      check($sformatf("R5 vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].irq});
    end

    // R4: edge and clear of the same bit in one cycle
    step(5'h00, 1'b1, A_EVT, 32'h1F, A_EVT);
    step(5'h00, 1'b1, A_MASK, 32'h1F, A_EVT);
    step(5'h10, 1'b1, A_EVT, 32'h10, A_EVT);
    check("R4 set wins", rd_data, 32'h10);
    check("R4 irq", {31'b0, irq}, 32'h1);

    // R6: command bit alone
    step(5'h10, 1'b1, A_EVT, 32'h80000000, A_EVT);
    check("R6 pulse high", {31'b0, upd}, 32'h1);
    check("R6 no clear, bit31 reads 0", rd_data, 32'h10);
    step(5'h10, 1'b0, A_MASK, 32'h0, A_EVT);
    check("R6 pulse one cycle", {31'b0, upd}, 32'h0);

    // R1: reset taken with events pending
    rst_n = 1'b0;
    #1;
    rd_addr = A_EVT;  #1 check("R1 evt in reset", rd_data, 32'h0);
    rd_addr = A_MASK; #1 check("R1 mask in reset", rd_data, 32'h0);
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    src = 5'h00;
    rst_n = 1'b1;
    @(negedge clk);
    rd_addr = A_EVT; #1 check("R1 evt after reset", rd_data, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule